// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the word address for every cycle of a four-word burst in a synchronous memory. The controller presents a full start address together with a load command. After that, each advance command moves the address to the next word of the same four-word group. Only the two least significant address bits take part in the burst. The upper bits keep the value they were given at the load.

Two orders are supported. Linear order counts the low pair upward and wraps past three. Interleaved order combines the starting low pair with a beat index by XOR. An active-high suspend input freezes the whole block for as long as it is held. The order is captured at each load, so it stays fixed for the burst that the load starts.

Top module: `burst_addr_gen`

## Requirements
- R1: After synchronous reset, `cur_addr` is zero, the captured order is linear and the beat index is zero.
- R2: On a clock edge where `suspend` is 0 and `step` is 0, the start address is loaded. From the next cycle `cur_addr` equals the `ext_addr` sampled at that edge.
- R3: When order 0 (linear) was captured, each edge with `suspend` 0 and `step` 1 adds one modulo 4 to `cur_addr[1:0]`. From a start of 2 the sequence is 2,3,0,1.
- R4: When order 1 (interleaved) was captured, `cur_addr[1:0]` on beat k (k = 0..3, counting advances since the load) equals start[1:0] XOR k. From a start of 1 the sequence is 1,0,3,2.
- R5: The fourth advance after a load brings `cur_addr` back to the loaded address, and the four-word sequence then repeats.
- R6: An advance never changes `cur_addr[ADDR_W-1:2]`.
- R7: While `suspend` is 1, `cur_addr` holds its value and `step`, `ext_addr` and `order_sel` have no effect.
- R8: `order_sel` is sampled only on load edges. A change of `order_sel` during a burst does not change the sequence.
- R9: A load in the middle of a burst starts a new burst at beat 0 from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| suspend | input | 1 | 1 holds all state |
| step | input | 1 | 0 loads `ext_addr`, 1 advances the burst |
| order_sel | input | 1 | Captured at load: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W | External start address |
| cur_addr | output | ADDR_W | Current word address |

## Verification
Two situations are hard to reach from the ports. The first is an `order_sel` change that arrives after a load but before the burst has run out. The second is a suspend cycle in the middle of a burst while the other inputs carry values that would load or advance the block. The stimulus starts an interleaved burst, flips `order_sel`, and then advances; a design that reads the pin live would then give a different low pair. The stimulus also holds `suspend` high while it drives a load command with a new address, then releases `suspend` and checks that the burst carries on from the same beat.

// File: rtl/bgen_pkg.sv
package bgen_pkg;

    localparam int LANE_W = 2;

    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // Low address pair for a given beat of the burst
    function automatic lane_t beat_lane(order_e ord, lane_t start, lane_t beat);
        lane_t r;
        if (ord == ORD_INTERLEAVE) r = start ^ beat;
        else                       r = start + beat;
        return r;
    endfunction

endpackage

// File: rtl/bgen_loader.sv
module bgen_loader
    import bgen_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              order_in,
    output logic [ADDR_W-1:0] start_q,
    output order_e            order_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            order_q <= ORD_LINEAR;
        end else if (en && load) begin
            start_q <= addr_in;
            order_q <= order_e'(order_in);
        end
    end
endmodule

// File: rtl/bgen_beat_ctr.sv
module bgen_beat_ctr
    import bgen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  load,
    output lane_t beat_q
);
    always_ff @(posedge clk) begin
        if (rst)       beat_q <= '0;
        else if (en) begin
            if (load)  beat_q <= '0;
            else       beat_q <= beat_q + lane_t'(1);
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bgen_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              suspend,
    input  logic              step,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int HI_W = ADDR_W - LANE_W;

    logic              en;
    logic              load;
    logic [ADDR_W-1:0] start_q;
    order_e            order_q;
    lane_t             beat_q;

    assign en   = !suspend;
    assign load = !step;

    bgen_loader #(.ADDR_W(ADDR_W)) u_loader (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .load     (load),
        .addr_in  (ext_addr),
        .order_in (order_sel),
        .start_q  (start_q),
        .order_q  (order_q)
    );

    bgen_beat_ctr u_beat (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .load   (load),
        .beat_q (beat_q)
    );

    generate
        if (HI_W > 0) begin : g_hi
            assign cur_addr[ADDR_W-1:LANE_W] = start_q[ADDR_W-1:LANE_W];
        end
    endgenerate

    assign cur_addr[LANE_W-1:0] = beat_lane(order_q, start_q[LANE_W-1:0], beat_q);
endmodule

// File: rtl/bgen_checker.sv
module bgen_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              suspend,
    input logic              step,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              order_q
);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        suspend |=> $stable(cur_addr));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!suspend && !step) |=> (cur_addr == $past(ext_addr)));

    p_upper_r6: assert property (@(posedge clk) disable iff (rst)
        (!suspend && step) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

    p_linear_r3: assert property (@(posedge clk) disable iff (rst)
        (!suspend && step && !order_q) |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

    p_ilv_r4: assert property (@(posedge clk) disable iff (rst)
        (!suspend && step && order_q) |=> (cur_addr[0] != $past(cur_addr[0])));
endmodule

bind burst_addr_gen bgen_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .suspend  (suspend),
    .step     (step),
    .ext_addr (ext_addr),
    .cur_addr (cur_addr),
    .order_q  (order_q)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int AW = 20;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst;
    logic          suspend;
    logic          step;
    logic          order_sel;
    logic [AW-1:0] ext_addr;
    logic [AW-1:0] cur_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .suspend(suspend), .step(step),
        .order_sel(order_sel), .ext_addr(ext_addr), .cur_addr(cur_addr)
    );

    // drive at a falling edge, let one rising edge pass, return at next falling edge
    task automatic tick(input logic s, input logic st, input logic o, input logic [AW-1:0] a);
        suspend = s; step = st; order_sel = o; ext_addr = a;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: cur_addr=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [AW-1:0] model(input logic [AW-1:0] s, input logic ilv, input int k);
        logic [1:0] lo;
        lo = ilv ? (s[1:0] ^ 2'(k)) : 2'((int'(s[1:0]) + k) % 4);
        return {s[AW-1:2], lo};
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        tick(1'b0, 1'b1, 1'b0, 20'h5A5A5);
        tick(1'b0, 1'b1, 1'b0, 20'h5A5A5);
        check("R1 reset", cur_addr, '0);
        rst = 1'b0;
        tick(1'b0, 1'b1, 1'b1, 20'h0);
        check("R1 linear after reset", cur_addr, 20'h1);
    endtask

    task automatic t_burst(input logic ilv, input logic [AW-1:0] base);
        for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] st;
            st = base | AW'(s);
            tick(1'b0, 1'b0, ilv, st);
            check("R2 load", cur_addr, st);
            for (int k = 1; k < 4; k++) begin
                tick(1'b0, 1'b1, ilv, 20'h0);
                check(ilv ? "R4 interleaved beat" : "R3 linear beat", cur_addr, model(st, ilv, k));
            end
        end
    endtask

    task automatic t_wrap();
        logic [AW-1:0] st;
        st = 20'hFFFFE;
        tick(1'b0, 1'b0, 1'b0, st);
        for (int k = 1; k < 9; k++) begin
            tick(1'b0, 1'b1, 1'b0, 20'h0);
            check("R6 upper unchanged", {cur_addr[AW-1:2], 2'b00}, {st[AW-1:2], 2'b00});
            check("R5 wrap", cur_addr, model(st, 1'b0, k));
        end
    endtask

    task automatic t_suspend();
        logic [AW-1:0] st;
        st = 20'h12341;
        tick(1'b0, 1'b0, 1'b1, st);
        tick(1'b0, 1'b1, 1'b1, 20'h0);
        check("R4 beat1", cur_addr, model(st, 1'b1, 1));
        tick(1'b1, 1'b0, 1'b0, 20'hABCDE);
        check("R7 load ignored", cur_addr, model(st, 1'b1, 1));
        tick(1'b1, 1'b1, 1'b0, 20'h0);
        check("R7 advance ignored", cur_addr, model(st, 1'b1, 1));
        tick(1'b0, 1'b1, 1'b1, 20'h0);
        check("R7 resume beat2", cur_addr, model(st, 1'b1, 2));
    endtask

    task automatic t_order_latch();
        logic [AW-1:0] st;
        st = 20'h00101;
        tick(1'b0, 1'b0, 1'b1, st);
        tick(1'b0, 1'b1, 1'b0, 20'h0);
        check("R8 order held", cur_addr, model(st, 1'b1, 1));
        tick(1'b0, 1'b1, 1'b0, 20'h0);
        check("R8 order held beat2", cur_addr, model(st, 1'b1, 2));
    endtask

    task automatic t_reload();
        logic [AW-1:0] a;
        logic [AW-1:0] b;
        a = 20'h00010; b = 20'h77773;
        tick(1'b0, 1'b0, 1'b0, a);
        tick(1'b0, 1'b1, 1'b0, 20'h0);
        tick(1'b0, 1'b0, 1'b1, b);
        check("R9 reload", cur_addr, b);
        tick(1'b0, 1'b1, 1'b1, 20'h0);
        check("R9 beat1 after reload", cur_addr, model(b, 1'b1, 1));
    endtask

    initial begin
        rst = 1'b1; suspend = 1'b0; step = 1'b1; order_sel = 1'b0; ext_addr = '0;
        @(negedge clk);
        t_reset();
        t_burst(1'b0, 20'hABC00);
        t_burst(1'b1, 20'h3F0F0);
        t_wrap();
        t_suspend();
        t_order_latch();
        t_reload();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: cur_addr=%h expected=completion", cur_addr);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule